// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block chooses, every clock, which of several hardware threads sends its next instruction into a shared pipeline. It keeps a program counter for each thread and works in one of two modes. In the interleaved mode it rotates through the threads one per cycle and passes over any thread that reports a stall. In the sticky mode it stays on one thread until that thread reports a long-latency stall. It then empties the pipeline with a one-cycle flush pulse and moves to another ready thread. The new thread issues nothing until a fixed refill delay has elapsed.

A preferred thread can be named. While that option is on, the preferred thread wins whenever it can issue. A redirect port overwrites any thread's program counter, for example after a taken branch or an exception. Stall flags come from the surrounding pipeline and memory system, one short-stall bit and one long-stall bit per thread. The outputs are combinational from the current state and the stall flags. The program counter shown is the value before the increment for that issue.

Top module: `thrd_sel_top`

## Requirements
- R1: With mode_coarse = 0, the issuing thread is the first ready thread in the order current+1, current+2, … modulo N, wrapping back to the current thread last. The current thread is the one that issued last. After reset the current thread is 0, so the first interleaved pick is thread 1 when all threads are ready.
- R2: In interleaved mode, a thread whose short_stall or long_stall bit is 1 is never chosen. Bit i of each stall vector belongs to thread i.
- R3: When every thread has at least one stall bit set, issue_vld and flush are 0, and no program counter and no current-thread choice changes.
- R4: Each thread has its own program counter. On an issue, only the issuing thread's counter grows by 4, and issue_pc shows the value before the increment.
- R5: When redir_en is 1, the PC of thread redir_tid becomes redir_pc at the next edge. This overrides the increment if that thread issues in the same cycle. The issue_pc of that cycle still shows the old value.
- R6: In interleaved mode with pref_en = 1, thread pref_tid issues whenever it has no stall bit set. Other threads issue only while it is stalled, and then in the order of R1.
- R7: With mode_coarse = 1, the current thread keeps issuing on consecutive cycles. A short stall on the current thread suppresses issue (issue_vld = 0) without changing threads. Stalls on other threads have no effect.
- R8: In sticky mode, when the current thread's long_stall is 1 and another thread is ready, flush is 1 for exactly that one cycle and issue_vld is 0. The new thread is pref_tid if pref_en = 1 and that thread is ready. Otherwise it is the first ready thread in the order of R1.
- R9: After a flush, issue_vld stays 0 for REFILL cycles (default 3). The new thread issues in the following cycle.
- R10: In sticky mode, if the current thread has a long stall and no other thread is ready, there is no flush, issue_vld is 0, and the block keeps the current thread.
- R11: A synchronous active-high reset sets every PC to 0, makes thread 0 current and cancels any pending refill delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_coarse | input | 1 | 0 = interleave every cycle, 1 = switch only on long stall |
| short_stall | input | N_THR | Per-thread short stall, bit i = thread i |
| long_stall | input | N_THR | Per-thread long-latency stall, bit i = thread i |
| pref_en | input | 1 | Enables the preferred thread |
| pref_tid | input | TID_W | Preferred thread number |
| redir_en | input | 1 | Loads a thread's PC |
| redir_tid | input | TID_W | Thread whose PC is loaded |
| redir_pc | input | PC_W | New PC value |
| issue_vld | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Issuing thread |
| issue_pc | output | PC_W | PC of the issuing thread before the increment |
| flush | output | 1 | One-cycle pipeline flush on a sticky-mode switch |

## Verification
The selector is driven first with all threads ready, which shows the plain rotation and its wrap. Single short stalls and single long stalls then show that either kind of stall is enough to skip a thread. Fully stalled patterns separate "no issue" from "issue of a stalled thread". Preferred-thread patterns, with the preferred thread free and then stalled, separate priority from rotation. In sticky mode, stalls on the current thread and on other threads show that only a long stall on the current thread causes a switch. One switch chooses the preferred thread over the rotation order, and one attempted switch finds no ready target. Redirects that land on an issuing thread and on a stalled thread separate load priority from the increment. A reset in the middle of a refill shows that the delay is cancelled.

// File: rtl/thrd_sel_pkg.sv
package thrd_sel_pkg;

   // per-cycle decision of the scheduler
   typedef enum logic [2:0] {
      ACT_IDLE   = 3'd0,   // nothing can issue
      ACT_ISSUE  = 3'd1,   // one thread issues
      ACT_HOLD   = 3'd2,   // sticky thread waits on a short stall
      ACT_SWITCH = 3'd3,   // sticky thread leaves, pipeline flushed
      ACT_REFILL = 3'd4    // pipeline refilling after a switch
   } act_e;

   localparam int unsigned PC_STEP_DEF = 4;

endpackage

// File: rtl/thrd_rr_pick.sv
module thrd_rr_pick #(
   parameter int unsigned N_THR = 4,
   parameter int unsigned TID_W = 2
) (
   input  logic [N_THR-1:0] ready,
   input  logic [TID_W-1:0] base,
   input  logic             pref_en,
   input  logic [TID_W-1:0] pref_tid,
   output logic             hit,
   output logic [TID_W-1:0] tid
);

   int unsigned k;

   always_comb begin
      hit = 1'b0;
      tid = base;
      k   = 0;
      if (pref_en && (32'(pref_tid) < N_THR) && ready[pref_tid]) begin
         hit = 1'b1;
         tid = pref_tid;
      end else begin
         for (int unsigned off = 1; off <= N_THR; off++) begin
            k = 32'(base) + off;
            if (k >= N_THR) k = k - N_THR;
            if (!hit && ready[k]) begin
               hit = 1'b1;
               tid = TID_W'(k);
            end
         end
      end
   end

endmodule

// File: rtl/thrd_pc_bank.sv
module thrd_pc_bank #(
   parameter int unsigned N_THR   = 4,
   parameter int unsigned TID_W   = 2,
   parameter int unsigned PC_W    = 32,
   parameter int unsigned PC_STEP = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv_en,
   input  logic [TID_W-1:0] adv_tid,
   input  logic             ld_en,
   input  logic [TID_W-1:0] ld_tid,
   input  logic [PC_W-1:0]  ld_val,
   input  logic [TID_W-1:0] rd_tid,
   output logic [PC_W-1:0]  rd_val
);

   localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

   logic [PC_W-1:0] pc_q [N_THR];

   for (genvar g = 0; g < N_THR; g++) begin : g_ctx
      always_ff @(posedge clk) begin
         if (rst)
            pc_q[g] <= '0;
         else if (ld_en && (ld_tid == TID_W'(g)))
            pc_q[g] <= ld_val;
         else if (adv_en && (adv_tid == TID_W'(g)))
            pc_q[g] <= pc_q[g] + STEP_V;
      end
   end

   always_comb begin
      rd_val = '0;
      if (32'(rd_tid) < N_THR) rd_val = pc_q[rd_tid];
   end

endmodule

// File: rtl/thrd_refill_timer.sv
module thrd_refill_timer #(
   parameter int unsigned REFILL = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy
);

   if (REFILL == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_cnt
      localparam int unsigned CNT_W = $clog2(REFILL + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (start)
            cnt_q <= CNT_W'(REFILL);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end

      assign busy = (cnt_q != '0);
   end

endmodule

// File: rtl/thrd_sched_ctl.sv
module thrd_sched_ctl
   import thrd_sel_pkg::*;
#(
   parameter int unsigned N_THR = 4,
   parameter int unsigned TID_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_coarse,
   input  logic [N_THR-1:0] short_stall,
   input  logic [N_THR-1:0] long_stall,
   input  logic             busy,
   input  logic             pick_hit,
   input  logic [TID_W-1:0] pick_tid,
   output logic [TID_W-1:0] cur_tid,
   output logic [TID_W-1:0] sel_tid,
   output act_e             act
);

   logic [TID_W-1:0] cur_q;
   logic             cur_long;
   logic             cur_short;

   assign cur_tid   = cur_q;
   assign cur_long  = long_stall[cur_q];
   assign cur_short = short_stall[cur_q];

   always_comb begin
      act     = ACT_IDLE;
      sel_tid = cur_q;
      if (busy) begin
         act = ACT_REFILL;
      end else if (!mode_coarse) begin
         if (pick_hit) begin
            act     = ACT_ISSUE;
            sel_tid = pick_tid;
         end
      end else if (cur_long) begin
         if (pick_hit) act = ACT_SWITCH;
      end else if (cur_short) begin
         act = ACT_HOLD;
      end else begin
         act = ACT_ISSUE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         cur_q <= '0;
      else if (act == ACT_ISSUE)
         cur_q <= sel_tid;
      else if (act == ACT_SWITCH)
         cur_q <= pick_tid;
   end

endmodule

// File: rtl/thrd_sel_top.sv
module thrd_sel_top
   import thrd_sel_pkg::*;
#(
   parameter int unsigned N_THR   = 4,
   parameter int unsigned PC_W    = 32,
   parameter int unsigned REFILL  = 3,
   parameter int unsigned PC_STEP = PC_STEP_DEF,
   localparam int unsigned TID_W  = (N_THR > 1) ? $clog2(N_THR) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_coarse,
   input  logic [N_THR-1:0] short_stall,
   input  logic [N_THR-1:0] long_stall,
   input  logic             pref_en,
   input  logic [TID_W-1:0] pref_tid,
   input  logic             redir_en,
   input  logic [TID_W-1:0] redir_tid,
   input  logic [PC_W-1:0]  redir_pc,
   output logic             issue_vld,
   output logic [TID_W-1:0] issue_tid,
   output logic [PC_W-1:0]  issue_pc,
   output logic             flush
);

   if (N_THR < 2) begin : g_bad_n
      $error("thrd_sel_top: N_THR must be at least 2");
   end
   if (PC_W < 8) begin : g_bad_w
      $error("thrd_sel_top: PC_W too small");
   end
   if ((PC_STEP == 0) || (PC_STEP >= (1 << PC_W))) begin : g_bad_s
      $error("thrd_sel_top: PC_STEP out of range");
   end

   logic [N_THR-1:0] ready;
   logic             pick_hit;
   logic [TID_W-1:0] pick_tid;
   logic [TID_W-1:0] cur_tid;
   logic [TID_W-1:0] sel_tid;
   logic             busy;
   act_e             act;

   assign ready = ~(short_stall | long_stall);

   thrd_rr_pick #(.N_THR(N_THR), .TID_W(TID_W)) u_pick (
      .ready    (ready),
      .base     (cur_tid),
      .pref_en  (pref_en),
      .pref_tid (pref_tid),
      .hit      (pick_hit),
      .tid      (pick_tid)
   );

   thrd_sched_ctl #(.N_THR(N_THR), .TID_W(TID_W)) u_ctl (
      .clk         (clk),
      .rst         (rst),
      .mode_coarse (mode_coarse),
      .short_stall (short_stall),
      .long_stall  (long_stall),
      .busy        (busy),
      .pick_hit    (pick_hit),
      .pick_tid    (pick_tid),
      .cur_tid     (cur_tid),
      .sel_tid     (sel_tid),
      .act         (act)
   );

   thrd_refill_timer #(.REFILL(REFILL)) u_refill (
      .clk   (clk),
      .rst   (rst),
      .start (flush),
      .busy  (busy)
   );

   thrd_pc_bank #(
      .N_THR(N_THR), .TID_W(TID_W), .PC_W(PC_W), .PC_STEP(PC_STEP)
   ) u_pcs (
      .clk     (clk),
      .rst     (rst),
      .adv_en  (issue_vld),
      .adv_tid (sel_tid),
      .ld_en   (redir_en),
      .ld_tid  (redir_tid),
      .ld_val  (redir_pc),
      .rd_tid  (sel_tid),
      .rd_val  (issue_pc)
   );

   assign issue_vld = (act == ACT_ISSUE);
   assign flush     = (act == ACT_SWITCH);
   assign issue_tid = sel_tid;

endmodule

// File: rtl/thrd_sel_chk.sv
module thrd_sel_chk #(
   parameter int unsigned N_THR   = 4,
   parameter int unsigned PC_W    = 32,
   parameter int unsigned REFILL  = 3,
   parameter int unsigned PC_STEP = 4,
   parameter int unsigned TID_W   = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             mode_coarse,
   input logic [N_THR-1:0] short_stall,
   input logic [N_THR-1:0] long_stall,
   input logic             pref_en,
   input logic [TID_W-1:0] pref_tid,
   input logic             redir_en,
   input logic [TID_W-1:0] redir_tid,
   input logic [PC_W-1:0]  redir_pc,
   input logic             issue_vld,
   input logic [TID_W-1:0] issue_tid,
   input logic [PC_W-1:0]  issue_pc,
   input logic             flush
);

   // cycles of enforced silence still owed after a flush
   int unsigned gap_cnt;
   logic        live;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_cnt <= 0;
         live    <= 1'b0;
      end else begin
         live <= 1'b1;
         if (flush)
            gap_cnt <= REFILL;
         else if (gap_cnt != 0)
            gap_cnt <= gap_cnt - 1;
      end
   end

   logic pref_free;
   assign pref_free = pref_en && (32'(pref_tid) < N_THR) &&
                      !short_stall[pref_tid] && !long_stall[pref_tid];

   // R8: flush lasts a single cycle
   a_r8_flush_single: assert property (@(posedge clk) disable iff (rst)
      flush |=> !flush);

   // R8: no issue in the flush cycle
   a_r8_flush_no_issue: assert property (@(posedge clk) disable iff (rst)
      flush |-> !issue_vld);

   // R9: refill window is quiet
   a_r9_refill_quiet: assert property (@(posedge clk) disable iff (rst)
      (gap_cnt != 0) |-> !issue_vld);

   // R2: interleaved issue never picks a stalled thread
   a_r2_fine_ready: assert property (@(posedge clk) disable iff (rst)
      (!mode_coarse && issue_vld) |->
         (!short_stall[issue_tid] && !long_stall[issue_tid]));

   // R3: nothing happens when every thread is stalled
   a_r3_all_stalled: assert property (@(posedge clk) disable iff (rst)
      (&(short_stall | long_stall)) |-> (!issue_vld && !flush));

   // R6: preferred thread wins in interleaved mode
   a_r6_pref_wins: assert property (@(posedge clk) disable iff (rst)
      (!mode_coarse && pref_free && (gap_cnt == 0)) |->
         (issue_vld && (issue_tid == pref_tid)));

   // R7: sticky mode keeps the same thread across back-to-back issues
   a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (live && mode_coarse && $past(mode_coarse) && issue_vld && $past(issue_vld))
         |-> (issue_tid == $past(issue_tid)));

   // R4: a thread that issues again shows its PC advanced by one step
   a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
      (issue_vld && !(redir_en && (redir_tid == issue_tid))) |=>
         (!(issue_vld && (issue_tid == $past(issue_tid))) ||
          (issue_pc == $past(issue_pc) + PC_W'(PC_STEP))));

   // R5: a redirect shows up as the next issue of that thread when it issues next cycle
   a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
      redir_en |=>
         (!(issue_vld && (issue_tid == $past(redir_tid))) ||
          (issue_pc == $past(redir_pc))));

endmodule

bind thrd_sel_top thrd_sel_chk #(
   .N_THR(N_THR), .PC_W(PC_W), .REFILL(REFILL), .PC_STEP(PC_STEP), .TID_W(TID_W)
) u_chk (
   .clk(clk), .rst(rst), .mode_coarse(mode_coarse),
   .short_stall(short_stall), .long_stall(long_stall),
   .pref_en(pref_en), .pref_tid(pref_tid),
   .redir_en(redir_en), .redir_tid(redir_tid), .redir_pc(redir_pc),
   .issue_vld(issue_vld), .issue_tid(issue_tid), .issue_pc(issue_pc),
   .flush(flush)
);

// File: tb/thrd_sel_top_tb_top.sv
module thrd_sel_top_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mode_coarse = 1'b0;
   logic [3:0]  short_stall = '0;
   logic [3:0]  long_stall  = '0;
   logic        pref_en  = 1'b0;
   logic [1:0]  pref_tid = '0;
   logic        redir_en = 1'b0;
   logic [1:0]  redir_tid = '0;
   logic [31:0] redir_pc  = '0;
   logic        issue_vld;
   logic [1:0]  issue_tid;
   logic [31:0] issue_pc;
   logic        flush;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   thrd_sel_top dut_i (
      .clk(clk), .rst(rst), .mode_coarse(mode_coarse),
      .short_stall(short_stall), .long_stall(long_stall),
      .pref_en(pref_en), .pref_tid(pref_tid),
      .redir_en(redir_en), .redir_tid(redir_tid), .redir_pc(redir_pc),
      .issue_vld(issue_vld), .issue_tid(issue_tid), .issue_pc(issue_pc),
      .flush(flush)
   );

   typedef struct packed {
      logic        md;
      logic [3:0]  ss;
      logic [3:0]  ls;
      logic        pe;
      logic [1:0]  pt;
      logic        re;
      logic [1:0]  rt;
      logic [31:0] rp;
      logic        ev;
      logic [1:0]  et;
      logic [31:0] ep;
      logic        ef;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t VECS [NV] = '{
      // interleaved mode
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd1, 32'h0,   1'b0, 8'd1},  // R1
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd2, 32'h0,   1'b0, 8'd1},  // R1
      '{1'b0, 4'h8, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd0, 32'h0,   1'b0, 8'd2},  // R2 short skip
      '{1'b0, 4'h0, 4'h2, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd2, 32'h4,   1'b0, 8'd2},  // R2 long skip
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd3, 32'h0,   1'b0, 8'd1},  // R1
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd0, 32'h4,   1'b0, 8'd4},  // R4 wrap
      '{1'b0, 4'hF, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd3},  // R3
      '{1'b0, 4'h0, 4'h0, 1'b1, 2'd3, 1'b0, 2'd0, 32'h0,   1'b1, 2'd3, 32'h4,   1'b0, 8'd6},  // R6 (R3 pc kept)
      '{1'b0, 4'h0, 4'h0, 1'b1, 2'd3, 1'b0, 2'd0, 32'h0,   1'b1, 2'd3, 32'h8,   1'b0, 8'd6},  // R6 repeat
      '{1'b0, 4'h8, 4'h0, 1'b1, 2'd3, 1'b0, 2'd0, 32'h0,   1'b1, 2'd0, 32'h8,   1'b0, 8'd6},  // R6 pref stalled
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b1, 2'd2, 32'h100, 1'b1, 2'd1, 32'h4,   1'b0, 8'd5},  // R5 load idle thread
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b1, 2'd2, 32'h200, 1'b1, 2'd2, 32'h100, 1'b0, 8'd5},  // R5 load beats step
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd3, 32'hC,   1'b0, 8'd4},  // R4
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd0, 32'hC,   1'b0, 8'd4},  // R4
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd1, 32'h8,   1'b0, 8'd4},  // R4
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd2, 32'h200, 1'b0, 8'd5},  // R5
      // sticky mode
      '{1'b1, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd2, 32'h204, 1'b0, 8'd7},  // R7
      '{1'b1, 4'h4, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd7},  // R7 short hold
      '{1'b1, 4'h1, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd2, 32'h208, 1'b0, 8'd7},  // R7 other stall ignored
      '{1'b1, 4'h0, 4'h4, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b1, 8'd8},  // R8 switch
      '{1'b1, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd9},  // R9
      '{1'b1, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd9},  // R9
      '{1'b1, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd9},  // R9
      '{1'b1, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd3, 32'h10,  1'b0, 8'd9},  // R9 first issue
      '{1'b1, 4'h7, 4'h8, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd10}, // R10 no target
      '{1'b1, 4'h0, 4'h8, 1'b1, 2'd2, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b1, 8'd8},  // R8 pref target
      '{1'b1, 4'h0, 4'h8, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd9},  // R9
      '{1'b1, 4'h0, 4'h8, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd9},  // R9
      '{1'b1, 4'h0, 4'h8, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd9},  // R9
      '{1'b1, 4'h0, 4'h8, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd2, 32'h20C, 1'b0, 8'd8},  // R8 new thread is 2
      // back to interleaved
      '{1'b0, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b1, 2'd3, 32'h14,  1'b0, 8'd1},  // R1
      '{1'b0, 4'h0, 4'hF, 1'b0, 2'd0, 1'b0, 2'd0, 32'h0,   1'b0, 2'd0, 32'h0,   1'b0, 8'd3}   // R3
   };

   task automatic apply(input vec_t v);
      mode_coarse = v.md;
      short_stall = v.ss;
      long_stall  = v.ls;
      pref_en     = v.pe;
      pref_tid    = v.pt;
      redir_en    = v.re;
      redir_tid   = v.rt;
      redir_pc    = v.rp;
   endtask

   task automatic check(input string req, input logic ev, input logic [1:0] et,
                        input logic [31:0] ep, input logic ef);
      logic bad;
      n_chk++;
      bad = (issue_vld !== ev) || (flush !== ef);
      if (ev) bad = bad || (issue_tid !== et) || (issue_pc !== ep);
      if (bad) begin
         n_fail++;
         $display("FAIL %s: got vld=%b tid=%0d pc=%h flush=%b, want vld=%b tid=%0d pc=%h flush=%b",
                  req, issue_vld, issue_tid, issue_pc, flush, ev, et, ep, ef);
      end
   endtask

   task automatic idle_in();
      apply('0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      string rq;
      repeat (3) @(posedge clk);
      // R11: reset state, interleaved view and sticky view
      @(negedge clk);
      idle_in();
      #1 check("R11 reset interleaved", 1'b1, 2'd1, 32'h0, 1'b0);
      mode_coarse = 1'b1;
      #1 check("R11 reset sticky", 1'b1, 2'd0, 32'h0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst = 1'b0;
         apply(VECS[i]);
         #1;
         rq = $sformatf("R%0d vec %0d", VECS[i].rq, i);
         check(rq, VECS[i].ev, VECS[i].et, VECS[i].ep, VECS[i].ef);
      end

      // R11: reset in mid-run
      @(negedge clk);
      idle_in();
      rst = 1'b1;
      @(negedge clk);
      mode_coarse = 1'b1;
      #1 check("R11 mid-run reset", 1'b1, 2'd0, 32'h0, 1'b0);

      // R3 + R5: redirect while every thread is stalled
      @(negedge clk);
      rst = 1'b0;
      idle_in();
      short_stall = 4'hF;
      redir_en = 1'b1; redir_tid = 2'd1; redir_pc = 32'h40;
      #1 check("R3 stalled redirect", 1'b0, 2'd0, 32'h0, 1'b0);
      @(negedge clk);
      idle_in();
      #1 check("R5 redirect seen", 1'b1, 2'd1, 32'h40, 1'b0);

      // R8 then R11: reset during the refill delay cancels it
      @(negedge clk);
      idle_in();
      mode_coarse = 1'b1;
      long_stall  = 4'h2;
      #1 check("R8 switch before reset", 1'b0, 2'd0, 32'h0, 1'b1);
      @(negedge clk);
      idle_in();
      rst = 1'b1;
      @(negedge clk);
      mode_coarse = 1'b1;
      #1 check("R11 refill cleared", 1'b1, 2'd0, 32'h0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule